// File: doc/BRIEF.md
# Daisy-Chainable SPI Status Slave

This block is the serial front end of a driver device. It connects to an SPI bus with an active-low chip select, a serial clock, serial data in and serial data out. The 16-bit diagnostic status word is captured when chip select falls. It is then shifted out while a 16-bit command word is shifted in. All pins are sampled by a faster system clock. The status source and the decoding of the command into control fields are outside this block.

Several copies can be chained, with each serial output feeding the next serial input. Each device delays the data by exactly one word, so every bit received leaves the serial output 16 serial clocks later. Status bit 0 is the thermal warning. It appears on the serial output as soon as chip select falls, with no serial clock needed, so a quick poll is possible. When chip select rises, the block checks the frame length. It accepts the last 16 received bits as the command only when the number of serial clocks is a nonzero multiple of 16. Any other frame is dropped and a frame-error strobe is raised.

Top module: `spi_status_chain`

## Requirements
- R1: While chip select (`csbN`) is high, the serial output is not driven (`soOe` = 0). After reset, `soOe` = 0, `cmdValid` = 0, `frameErr` = 0 and `cmdWord` = 0.
- R2: A few system clocks after `csbN` falls, `soOe` = 1 and `soData` equals `statusIn[0]` (thermal warning: 1 = active, 0 = none). No serial clock edge is needed for this.
- R3: `statusIn` is captured when `csbN` falls. The first 16 bits out, sampled before each serial clock rising edge, are status bit 0 and then bits 15 down to 1. Changes to `statusIn` during the frame do not change these bits.
- R4: `si` is sampled on the serial clock rising edge, and `soData` changes after the falling edge. A bit received at rising edge k appears on `soData` before rising edge k+16.
- R5: When `csbN` rises after a nonzero multiple of 16 serial clocks, `cmdWord` takes the last 16 bits received, with the earliest of them at bit 15. `cmdValid` pulses for one system clock. In a 32-clock frame, only the second word counts. Command bit 0 is the status-reset request, bit 13 selects the overcurrent mode and bit 15 enables overvoltage lockout.
- R6: When `csbN` rises after a number of serial clocks that is zero or not a multiple of 16, `cmdWord` keeps its value, `cmdValid` stays low and `frameErr` pulses for one system clock.
- R7: Serial clock and data activity while `csbN` is high has no effect: no strobe fires, `cmdWord` keeps its value and the next frame starts cleanly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all SPI pins |
| rstN | input | 1 | Active-low asynchronous reset |
| csbN | input | 1 | SPI chip select, active low |
| sclk | input | 1 | SPI serial clock, idle low |
| si | input | 1 | SPI serial data in |
| statusIn | input | 16 | Diagnostic status word (bit 0 thermal warning, 14 under-load, 15 supply fail) |
| soData | output | 1 | Serial data out value |
| soOe | output | 1 | Serial data out drive enable (0 = high impedance) |
| cmdWord | output | 16 | Last accepted command word |
| cmdValid | output | 1 | One-cycle strobe when a command is accepted |
| frameErr | output | 1 | One-cycle strobe when a frame is rejected |

## Verification
The assertions assume that every SPI pin level is held for several system clocks. They also assume that chip select never moves in the same synchronized cycle as a serial clock edge, so each pin edge is seen once and in order. The bench holds each serial clock half period for six system clocks. It always separates chip select edges from serial clock edges by a full half period, and it keeps the serial clock low whenever chip select moves.

// File: rtl/spi_chain_pkg.sv
package spi_chain_pkg;
  localparam int WordBits = 16;

  typedef struct packed {
    logic load;    // capture status at frame start
    logic sample;  // capture serial input (SCLK rise)
    logic shift;   // advance shift register (SCLK fall)
    logic commit;  // frame length valid, take command
    logic reject;  // frame length invalid
  } ctlStrobe_t;
endpackage

// File: rtl/spi_chain_ctrl.sv
module spi_chain_ctrl
  import spi_chain_pkg::*;
#(
  parameter int SyncStages = 2,
  parameter int FrameBits  = WordBits
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       csbN,
  input  logic       sclk,
  output ctlStrobe_t strb,
  output logic       frameActive
);
  localparam int CntW = $clog2(FrameBits);

  logic [SyncStages-1:0] csbSync;
  logic [SyncStages-1:0] sclkSync;
  logic csbD, sclkD;
  logic [CntW-1:0] bitCnt;
  logic anyEdge;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csbSync  <= '1;
      sclkSync <= '0;
      csbD     <= 1'b1;
      sclkD    <= 1'b0;
    end else begin
      csbSync  <= {csbSync[SyncStages-2:0], csbN};
      sclkSync <= {sclkSync[SyncStages-2:0], sclk};
      csbD     <= csbSync[SyncStages-1];
      sclkD    <= sclkSync[SyncStages-1];
    end
  end

  logic csbNow, sclkNow, inFrame;
  assign csbNow  = csbSync[SyncStages-1];
  assign sclkNow = sclkSync[SyncStages-1];
  assign inFrame = !csbNow && !csbD;

  always_comb begin
    strb        = '0;
    strb.load   = csbD && !csbNow;
    strb.sample = inFrame && sclkNow && !sclkD;
    strb.shift  = inFrame && !sclkNow && sclkD;
    strb.commit = !csbD && csbNow && anyEdge && (bitCnt == '0);
    strb.reject = !csbD && csbNow && !(anyEdge && (bitCnt == '0));
  end

  assign frameActive = !csbD;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt  <= '0;
      anyEdge <= 1'b0;
    end else if (strb.load) begin
      bitCnt  <= '0;
      anyEdge <= 1'b0;
    end else if (strb.sample) begin
      bitCnt  <= (bitCnt == CntW'(FrameBits - 1)) ? '0 : bitCnt + 1'b1;
      anyEdge <= 1'b1;
    end
  end

  // R6
  load_clears_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> (bitCnt == '0 && !anyEdge));

  // R7
  idle_no_edges_chk: assert property (@(posedge clk) disable iff (!rstN)
    csbD |-> !(strb.sample || strb.shift));
endmodule

// File: rtl/spi_chain_dp.sv
module spi_chain_dp
  import spi_chain_pkg::*;
#(
  parameter int SyncStages = 2,
  parameter int FrameBits  = WordBits
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 si,
  input  logic [FrameBits-1:0] statusIn,
  input  ctlStrobe_t           strb,
  output logic                 soData,
  output logic [FrameBits-1:0] cmdWord,
  output logic                 cmdValid,
  output logic                 frameErr
);
  logic [SyncStages-1:0] siSync;
  logic siHold;
  logic [FrameBits-1:0] shReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) siSync <= '0;
    else       siSync <= {siSync[SyncStages-2:0], si};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      siHold   <= 1'b0;
      shReg    <= '0;
      cmdWord  <= '0;
      cmdValid <= 1'b0;
      frameErr <= 1'b0;
    end else begin
      cmdValid <= strb.commit;
      frameErr <= strb.reject;
      if (strb.sample) siHold <= siSync[SyncStages-1];
      if (strb.load)
        shReg <= {statusIn[0], statusIn[FrameBits-1:1]};
      else if (strb.shift)
        shReg <= {shReg[FrameBits-2:0], siHold};
      if (strb.commit) cmdWord <= shReg;
    end
  end

  assign soData = shReg[FrameBits-1];

  // R3
  load_shift_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.load && (strb.shift || strb.sample)));

  // R6
  cmd_hold_on_reject_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameErr |-> $stable(cmdWord));
endmodule

// File: rtl/spi_status_chain.sv
module spi_status_chain
  import spi_chain_pkg::*;
#(
  parameter int SyncStages = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                csbN,
  input  logic                sclk,
  input  logic                si,
  input  logic [WordBits-1:0] statusIn,
  output logic                soData,
  output logic                soOe,
  output logic [WordBits-1:0] cmdWord,
  output logic                cmdValid,
  output logic                frameErr
);
  ctlStrobe_t strb;

  spi_chain_ctrl #(.SyncStages(SyncStages), .FrameBits(WordBits)) u_ctrl (
    .clk(clk), .rstN(rstN), .csbN(csbN), .sclk(sclk),
    .strb(strb), .frameActive(soOe)
  );

  spi_chain_dp #(.SyncStages(SyncStages), .FrameBits(WordBits)) u_dp (
    .clk(clk), .rstN(rstN), .si(si), .statusIn(statusIn), .strb(strb),
    .soData(soData), .cmdWord(cmdWord), .cmdValid(cmdValid), .frameErr(frameErr)
  );

  // R2
  warn_at_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(soOe) |-> soData == $past(statusIn[0]));

  // R5
  commit_in_frame_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> $past(soOe));

  // R6
  strobes_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({cmdValid, frameErr}));
endmodule

// File: tb/spi_status_chain_bench.sv
module spi_status_chain_bench;
  localparam int HALF = 6;

  logic clk = 0, rstN = 0, csbN = 1, sclk = 0, si = 0;
  logic [15:0] statusIn = '0;
  logic soData, soOe, cmdValid, frameErr;
  logic [15:0] cmdWord;
  int checks = 0, fails = 0, nValid = 0, nErr = 0;

  always #4 clk = ~clk;

  spi_status_chain u_spi_status_chain (
    .clk(clk), .rstN(rstN), .csbN(csbN), .sclk(sclk), .si(si),
    .statusIn(statusIn), .soData(soData), .soOe(soOe),
    .cmdWord(cmdWord), .cmdValid(cmdValid), .frameErr(frameErr)
  );

  always @(negedge clk) begin
    if (cmdValid) nValid++;
    if (frameErr) nErr++;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic frameStart();
    csbN = 0;
    waitClk(HALF);
  endtask

  task automatic frameEnd();
    waitClk(HALF);
    csbN = 1;
    waitClk(HALF + 2);
  endtask

  task automatic xferBit(input logic din, output logic dout);
    si = din;
    waitClk(HALF);
    dout = soData;
    sclk = 1;
    waitClk(HALF);
    sclk = 0;
  endtask

  task automatic xferWord(input logic [15:0] din, output logic [15:0] dout);
    for (int i = 15; i >= 0; i--) begin
      logic b;
      xferBit(din[i], b);
      dout[i] = b;
    end
  endtask

  task automatic testReset();
    chk("R1 soOe reset", soOe, 0);
    chk("R1 cmdWord reset", cmdWord, 0);
    chk("R1 strobes reset", {cmdValid, frameErr}, 0);
  endtask

  task automatic testWarnPoll();
    int e0 = nErr;
    statusIn = 16'h0001;
    frameStart();
    chk("R2 soOe in frame", soOe, 1);
    chk("R2 warning high", soData, 1);
    frameEnd();
    chk("R1 soOe idle", soOe, 0);
    chk("R6 empty frame error", nErr - e0, 1);
    statusIn = 16'hFFFE;
    frameStart();
    chk("R2 warning low", soData, 0);
    frameEnd();
  endtask

  task automatic testSingle();
    logic [15:0] got;
    int v0 = nValid;
    statusIn = 16'hA5C3;
    frameStart();
    statusIn = 16'h0000;
    xferWord(16'h8001, got);
    chk("R3 status order", got, {1'b1, 15'h52E1});
    frameEnd();
    chk("R5 cmdWord single", cmdWord, 16'h8001);
    chk("R5 one cmdValid", nValid - v0, 1);
  endtask

  task automatic testChain();
    logic [15:0] w1, w2;
    int v0 = nValid, e0 = nErr;
    statusIn = 16'h0002;
    frameStart();
    xferWord(16'h2A5B, w1);
    xferWord(16'h6001, w2);
    chk("R3 status first word", w1, 16'h0001);
    chk("R4 passthrough word", w2, 16'h2A5B);
    frameEnd();
    chk("R5 cmdWord chain", cmdWord, 16'h6001);
    chk("R5 chain strobes", {nValid - v0, nErr - e0}, {32'd1, 32'd0});
  endtask

  task automatic testBadLength();
    logic [15:0] w;
    logic b;
    int v0 = nValid, e0 = nErr;
    frameStart();
    xferWord(16'h1234, w);
    for (int i = 0; i < 4; i++) xferBit(1'b1, b);
    frameEnd();
    chk("R6 cmdWord kept", cmdWord, 16'h6001);
    chk("R6 error strobe", nErr - e0, 1);
    chk("R6 no cmdValid", nValid - v0, 0);
  endtask

  task automatic testIdleTraffic();
    logic [15:0] got;
    int v0 = nValid, e0 = nErr;
    for (int i = 0; i < 16; i++) begin
      si = i[0];
      waitClk(HALF);
      sclk = 1;
      waitClk(HALF);
      sclk = 0;
    end
    waitClk(HALF);
    chk("R7 no strobes idle", {nValid - v0, nErr - e0}, 0);
    chk("R7 cmdWord kept", cmdWord, 16'h6001);
    chk("R7 soOe idle", soOe, 0);
    statusIn = 16'h8000;
    frameStart();
    xferWord(16'hC3C3, got);
    chk("R7 clean next frame", got, 16'h4000);
    frameEnd();
    chk("R5 cmdWord after idle", cmdWord, 16'hC3C3);
  endtask

  initial begin
    fork
      begin
        waitClk(5);
        rstN = 1;
        waitClk(3);
        testReset();
        testWarnPoll();
        testSingle();
        testChain();
        testBadLength();
        testIdleTraffic();
      end
      begin
        waitClk(100000);
        fails++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule